// File: doc/BRIEF.md
# Sector Write-Protect Checker

This block decides whether a program or erase request aimed at a given page of a serial flash array may go ahead. It folds the page number onto a sector layout that is not uniform: the first sector is split into a small part of 8 pages and a large part of 248 pages, and every later sector spans 256 pages. It then looks up that sector's bit in a protection map held inside the block. The verdict combines the map bit with a software enable flag and with the active-low write-protect pin.

A command sequencer drives one command per cycle through a small command port. The four commands are: check a page, set the software enable, clear the software enable, and write the protection map. A check produces a one-cycle allow or reject pulse on the following cycle. While the write-protect pin is low, every sector marked in the map is protected whatever the software enable says. In the same state, writes to the map are dropped. The enable commands are still honoured while the pin is low. The map is read back on a port so that the sequencer can report it.

Top module: `sect_wp_check`

## Requirements
- R1: After reset the protection map reads all zeros, the software enable is clear, and both allow and reject are low.
- R2: Pages 0 to 7 use map bit 0, and pages 8 to 255 use map bit 1.
- R3: For k from 1 to 7, pages 256*k to 256*k+255 use map bit k+1, so page 2047 uses bit 8.
- R4: With wpN low, a check on a page whose map bit is 1 yields reject, even when the software enable is clear.
- R5: With wpN high and the software enable clear, every check yields allow, whatever the map holds.
- R6: With wpN high and the software enable set, a check yields reject when the page's map bit is 1 and allow when it is 0.
- R7: A map write (cmdCode 2'b11, data on mapData) loads protMap on the next cycle when wpN is high, and is ignored when wpN is low.
- R8: Set-enable (cmdCode 2'b01) and clear-enable (cmdCode 2'b10) take effect while wpN is low, as well as while it is high.
- R9: A check (cmdCode 2'b00 with cmdValid high) raises exactly one of allow and reject for one cycle, on the cycle after the command. Both outputs stay low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wpN | input | 1 | Write-protect pin, active low |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 2 | 00 check, 01 set enable, 10 clear enable, 11 map write |
| reqPage | input | 11 | Page number for a check |
| mapData | input | 9 | New protection map for a map write |
| allowOut | output | 1 | Request permitted (one-cycle pulse) |
| rejectOut | output | 1 | Request refused (one-cycle pulse) |
| protMap | output | 9 | Current protection map |

## Verification
The assertions assume that the sequencer presents at most one command per cycle. They also assume that wpN, reqPage and mapData hold steady around the clock edge that samples a command, since the verdict is taken from their values at that edge. The stimulus respects both points: it changes every input only on the falling clock edge, issues each command for a single cycle, and leaves the command port idle between commands. It changes wpN only while no command is pending.

// File: rtl/sect_wp_pkg.sv
package sect_wp_pkg;

  typedef enum logic [1:0] {
    CMD_CHECK  = 2'b00,
    CMD_EN_SET = 2'b01,
    CMD_EN_CLR = 2'b10,
    CMD_MAP_WR = 2'b11
  } wpCmd_e;

  typedef struct packed {
    logic check;
    logic enSet;
    logic enClr;
    logic mapWrite;
  } wpStrobe_t;

endpackage

// File: rtl/sect_wp_ctrl.sv
module sect_wp_ctrl
  import sect_wp_pkg::*;
(
  input  logic       cmdValid,
  input  logic [1:0] cmdCode,
  input  logic       wpN,
  output wpStrobe_t  stb
);

  wpCmd_e cmd;

  always_comb begin
    cmd          = wpCmd_e'(cmdCode);
    stb          = '0;
    stb.check    = cmdValid && (cmd == CMD_CHECK);
    stb.enSet    = cmdValid && (cmd == CMD_EN_SET);
    stb.enClr    = cmdValid && (cmd == CMD_EN_CLR);
    // map changes are refused while the pin holds protection
    stb.mapWrite = cmdValid && (cmd == CMD_MAP_WR) && wpN;
  end

  always_comb begin
    assert ($onehot0(stb)) else $error("p_one_strobe_r9");
  end

endmodule

// File: rtl/sect_wp_datapath.sv
module sect_wp_datapath
  import sect_wp_pkg::*;
#(
  parameter int PAGE_W     = 11,
  parameter int SECT_LOG2  = 8,
  parameter int SMALL_LOG2 = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wpN,
  input  wpStrobe_t                              stb,
  input  logic [PAGE_W-1:0]                      reqPage,
  input  logic [(1<<(PAGE_W-SECT_LOG2)):0]       mapData,
  output logic                                   allowOut,
  output logic                                   rejectOut,
  output logic [(1<<(PAGE_W-SECT_LOG2)):0]       protMap
);

  localparam int HI_W      = PAGE_W - SECT_LOG2;
  localparam int NUM_BIG   = 1 << HI_W;
  localparam int NUM_SECT  = NUM_BIG + 1;
  localparam int LOW_W     = SECT_LOG2 - SMALL_LOG2;

  logic [HI_W-1:0]     pageHi;
  logic [LOW_W-1:0]    pageMid;
  logic [NUM_SECT-1:0] sectHit;
  logic                swEn;
  logic                isProt;

  assign pageHi  = reqPage[PAGE_W-1:SECT_LOG2];
  assign pageMid = reqPage[SECT_LOG2-1:SMALL_LOG2];

  // first sector split in a small and a large part
  assign sectHit[0] = (pageHi == '0) && (pageMid == '0);
  assign sectHit[1] = (pageHi == '0) && (pageMid != '0);

  genvar k;
  generate
    for (k = 1; k < NUM_BIG; k++) begin : g_big
      assign sectHit[k+1] = (pageHi == HI_W'(k));
    end
  endgenerate

  assign isProt = |(sectHit & protMap) && (swEn || !wpN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protMap   <= '0;
      swEn      <= 1'b0;
      allowOut  <= 1'b0;
      rejectOut <= 1'b0;
    end else begin
      if (stb.mapWrite) protMap <= mapData;
      if (stb.enSet)    swEn <= 1'b1;
      else if (stb.enClr) swEn <= 1'b0;
      allowOut  <= stb.check && !isProt;
      rejectOut <= stb.check && isProt;
    end
  end

  p_map_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wpN |=> $stable(protMap));

  p_pin_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.check && !wpN && protMap[0] && (reqPage < PAGE_W'(1 << SMALL_LOG2))) |=> rejectOut);

  p_sw_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.check && wpN && !swEn) |=> allowOut);

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (allowOut || rejectOut) |-> $past(stb.check));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(allowOut && rejectOut));

endmodule

// File: rtl/sect_wp_check.sv
module sect_wp_check
  import sect_wp_pkg::*;
#(
  parameter int PAGE_W     = 11,
  parameter int SECT_LOG2  = 8,
  parameter int SMALL_LOG2 = 3,
  localparam int MAP_W     = (1 << (PAGE_W - SECT_LOG2)) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wpN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdCode,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [MAP_W-1:0]  mapData,
  output logic              allowOut,
  output logic              rejectOut,
  output logic [MAP_W-1:0]  protMap
);

  wpStrobe_t stb;

  sect_wp_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .wpN      (wpN),
    .stb      (stb)
  );

  sect_wp_datapath #(
    .PAGE_W     (PAGE_W),
    .SECT_LOG2  (SECT_LOG2),
    .SMALL_LOG2 (SMALL_LOG2)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wpN       (wpN),
    .stb       (stb),
    .reqPage   (reqPage),
    .mapData   (mapData),
    .allowOut  (allowOut),
    .rejectOut (rejectOut),
    .protMap   (protMap)
  );

endmodule

// File: tb/sect_wp_check_tb.sv
module sect_wp_check_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wpN = 1'b1;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdCode = 2'b00;
  logic [10:0] reqPage = '0;
  logic [8:0]  mapData = '0;
  logic        allowOut, rejectOut;
  logic [8:0]  protMap;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sect_wp_check u_dut (
    .clk(clk), .rst_n(rst_n), .wpN(wpN), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .reqPage(reqPage), .mapData(mapData),
    .allowOut(allowOut), .rejectOut(rejectOut), .protMap(protMap)
  );

  // {wpN, enable, map[8:0], page[10:0], expectReject}
  localparam logic [22:0] VEC [12] = '{
    {1'b1, 1'b1, 9'h001, 11'd7,    1'b1},  // R2 last small page
    {1'b1, 1'b1, 9'h001, 11'd8,    1'b0},  // R2 first large page
    {1'b1, 1'b1, 9'h002, 11'd8,    1'b1},  // R2
    {1'b1, 1'b1, 9'h002, 11'd255,  1'b1},  // R2
    {1'b1, 1'b1, 9'h002, 11'd256,  1'b0},  // R3 boundary
    {1'b1, 1'b1, 9'h004, 11'd256,  1'b1},  // R3
    {1'b1, 1'b1, 9'h100, 11'd2047, 1'b1},  // R3 last page
    {1'b1, 1'b1, 9'h0FF, 11'd2047, 1'b0},  // R6 unmarked
    {1'b0, 1'b0, 9'h080, 11'd1600, 1'b1},  // R4
    {1'b1, 1'b0, 9'h1FF, 11'd100,  1'b0},  // R5
    {1'b1, 1'b1, 9'h1FE, 11'd3,    1'b0},  // R6
    {1'b0, 1'b0, 9'h000, 11'd500,  1'b0}   // R4 unmarked
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] code, input logic [10:0] page, input logic [8:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code; reqPage = page; mapData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic verdict(input string req, input logic expRej);
    check(req, {7'd0, allowOut, rejectOut}, {7'd0, !expRej, expRej});
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 map", protMap, 9'h000);
    check("R1 pulses", {7'd0, allowOut, rejectOut}, 9'd0);
    rst_n = 1'b1;
    doCmd(2'b00, 11'd0, 9'h000);
    verdict("R1 enable clear", 1'b0);

    for (int i = 0; i < 12; i++) begin
      wpN = 1'b1;
      doCmd(2'b11, 11'd0, VEC[i][20:12]);
      doCmd(VEC[i][21] ? 2'b01 : 2'b10, 11'd0, 9'h000);
      wpN = VEC[i][22];
      doCmd(2'b00, VEC[i][11:1], 9'h000);
      verdict($sformatf("R2/R3/R4/R5/R6 vector %0d", i), VEC[i][0]);
    end

    // R7 map write accepted with pin high, ignored with pin low
    wpN = 1'b1;
    doCmd(2'b11, 11'd0, 9'h155);
    check("R7 write accepted", protMap, 9'h155);
    wpN = 1'b0;
    doCmd(2'b11, 11'd0, 9'h0AA);
    check("R7 write ignored", protMap, 9'h155);
    doCmd(2'b00, 11'd0, 9'h000);
    verdict("R7 old map still applies", 1'b1);

    // R8 enable set while pin low, observed after pin rises
    wpN = 1'b1;
    doCmd(2'b10, 11'd0, 9'h000);
    wpN = 1'b0;
    doCmd(2'b01, 11'd0, 9'h000);
    wpN = 1'b1;
    doCmd(2'b00, 11'd0, 9'h000);
    verdict("R8 set under pin", 1'b1);
    wpN = 1'b0;
    doCmd(2'b10, 11'd0, 9'h000);
    wpN = 1'b1;
    doCmd(2'b00, 11'd0, 9'h000);
    verdict("R8 clear under pin", 1'b0);

    // R9 pulse lasts one cycle, no pulse for other commands
    @(negedge clk);
    check("R9 pulse width", {7'd0, allowOut, rejectOut}, 9'd0);
    doCmd(2'b01, 11'd0, 9'h000);
    check("R9 no pulse on enable", {7'd0, allowOut, rejectOut}, 9'd0);
    doCmd(2'b11, 11'd0, 9'h000);
    check("R9 no pulse on map write", {7'd0, allowOut, rejectOut}, 9'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule